// File: doc/BRIEF.md
# Resampler Phase Table Sequencer

This block turns one scaling ratio into the list of entries that fill a resampler's phase table. A request carries an output count and a source count for one scaling period. The block first divides both by their greatest common divisor. If the reduced output count is larger than the table depth, or either count is zero, it flags an error and emits nothing.

An accepted ratio is handled by one of three integer recurrences: one for shrinking, one for enlarging by a whole factor, and one for enlarging by a fraction. Each recurrence produces a weight and an offset for every table entry. The weight is in units of 1/512 of the first of two neighbouring source pixels. The offset is the number of source pixels to advance after that entry.

Entries leave on a valid/ready stream toward a coefficient generator or table writer. A header word of all ones comes before the entries, so that the receiver can rewind its write pointer. One shared serial divider does every division and remainder, including the steps of the common-divisor search. A busy flag turns new requests away until the final entry has been taken.

Top module: `ptab_seq`

## Requirements
- R1: After reset, `busy`, `out_valid` and `err` are 0 and `mode` is 0.
- R2: A request is rejected in any of these cases: either count is zero, or the count num divided by gcd(num, denom) exceeds TABLE_N (31 by default). On rejection `err` is high for exactly one cycle, no word is emitted and `mode` reads 0.
- R3: For an accepted ratio, the first word on the stream has every bit set.
- R4: After the ratio is reduced to n/d, `mode` reads 1 (shrink) when d > n. Otherwise it reads 2 (whole-factor enlarge) when d = 1, and 3 (fractional enlarge) in every other case. It holds that value until the next request is accepted, and it is never 0 while a word is offered.
- R5: Fractional enlarge emits n entries with nearest flag 0. It starts from a=0. For each entry: weight = 512 - (512·a)/n; then a += d; offset = 1 if a ≥ n, else 0; and if the offset is 1, a -= n.
- R6: Whole-factor enlarge emits n entries. Every entry has weight 512 and nearest flag 1. Only the final entry has offset 1; all the others have offset 0.
- R7: Shrink emits n entries with nearest flag 0. It starts from a=d. For each entry: a = n + (a-n) mod 2n; weight = 512 - 512·(a-n)/(2n); then a += 2d; offset = (a-n)/(2n). All divisions truncate.
- R8: Word layout: bits [9:0] hold the weight, bits [17:10] the offset and bit 18 the nearest flag. `out_last` is high on the final entry only, so a ratio yields n+1 words including the header.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` and `out_last` do not change.
- R10: `busy` goes high in the cycle after a request is accepted. It falls in the cycle after the final entry is accepted or after the error cycle. Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; taken when `busy` is low |
| req_num | input | RAT_W | Output count over one period |
| req_denom | input | RAT_W | Source count over one period |
| busy | output | 1 | A request is being worked on |
| err | output | 1 | One-cycle rejection flag |
| mode | output | 2 | Recurrence in use: 0 none, 1 shrink, 2 whole-factor, 3 fractional |
| out_valid | output | 1 | A word is offered |
| out_ready | input | 1 | The receiver takes the word |
| out_word | output | RAT_W+WT_SH+2 | Header or {nearest, offset, weight} |
| out_last | output | 1 | Final entry of the table |

## Verification
Some properties are checked on every cycle by the assertions:
- the stream holds steady under back-pressure;
- no word is offered outside a busy period or with the mode unset;
- the error flag never lasts two cycles and never coincides with a word;
- every non-header weight lies in 1..512, and fractional-enlarge offsets never exceed 1;
- the divider is never started twice, never started with a zero divisor, and always ends with a remainder below its divisor.

The bench scenarios cover what no single-cycle property can see:
- the exact sequence of weights and offsets produced by each recurrence;
- the common-divisor reduction and the table-depth rejection;
- the choice among the three recurrences;
- the refusal of requests made while busy, tested over a long shrink table.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

   // Recurrence chosen for the reduced ratio; NONE also marks a rejection
   typedef enum logic [1:0] {
      MODE_NONE = 2'd0,
      MODE_DOWN = 2'd1,
      MODE_INT  = 2'd2,
      MODE_FRAC = 2'd3
   } ptab_mode_e;

endpackage

// File: rtl/ptab_div.sv
// Restoring divider, one quotient bit per cycle, results held after done.
module ptab_div #(
   parameter int DVD_W = 18,
   parameter int DVS_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             done,
   output logic [DVD_W-1:0] quo,
   output logic [DVS_W-1:0] rem
);

   localparam int CNT_W = $clog2(DVD_W + 1);

   generate
      if (DVD_W < 2) begin : g_bad_dvd
         $error("ptab_div: DVD_W must be at least 2");
      end
      if (DVS_W < 2) begin : g_bad_dvs
         $error("ptab_div: DVS_W must be at least 2");
      end
   endgenerate

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DVD_W-1:0] shf_q;
   logic [DVS_W-1:0] dvs_q;
   logic [DVS_W:0]   trial;
   logic [DVS_W:0]   diff;
   logic             fits;

   always_comb begin
      trial = {rem, shf_q[DVD_W-1]};
      diff  = trial - {1'b0, dvs_q};
      fits  = (trial >= {1'b0, dvs_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         shf_q <= '0;
         dvs_q <= '0;
         quo   <= '0;
         rem   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(DVD_W);
            shf_q <= dividend;
            dvs_q <= divisor;
            quo   <= '0;
            rem   <= '0;
         end else if (run_q) begin
            shf_q <= {shf_q[DVD_W-2:0], 1'b0};
            quo   <= {quo[DVD_W-2:0], fits};
            rem   <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end

   AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (divisor != '0)); // R7
   AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run_q); // R5
   AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem < dvs_q)); // R7

endmodule

// File: rtl/ptab_ctrl.sv
// Sequencer: gcd reduction, limit check, mode choice and the three recurrences.
module ptab_ctrl
   import ptab_pkg::*;
#(
   parameter int RAT_W   = 8,
   parameter int TABLE_N = 31,
   parameter int WT_SH   = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [RAT_W-1:0]         req_num,
   input  logic [RAT_W-1:0]         req_denom,
   output logic                     busy,
   output logic                     err,
   output logic [1:0]               mode,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [RAT_W+WT_SH+1:0]   out_word,
   output logic                     out_last,
   output logic                     div_start,
   output logic [RAT_W+WT_SH:0]     div_dvd,
   output logic [RAT_W:0]           div_dvs,
   input  logic                     div_done,
   input  logic [RAT_W+WT_SH:0]     div_quo,
   input  logic [RAT_W:0]           div_rem
);

   localparam int WT_W   = WT_SH + 1;
   localparam int DVD_W  = RAT_W + WT_SH + 1;
   localparam int DVS_W  = RAT_W + 1;
   localparam int ACC_W  = RAT_W + 2;
   localparam int WORD_W = RAT_W + WT_SH + 2;
   localparam logic [WT_W-1:0]  UNITY   = WT_W'(1) << WT_SH;
   localparam logic [RAT_W-1:0] TAB_LIM = RAT_W'(TABLE_N);

   generate
      if (TABLE_N < 1 || TABLE_N >= (1 << RAT_W)) begin : g_bad_tab
         $error("ptab_ctrl: TABLE_N must lie in 1 .. 2**RAT_W-1");
      end
      if (WT_SH < 1) begin : g_bad_wt
         $error("ptab_ctrl: WT_SH must be at least 1");
      end
   endgenerate

   typedef enum logic [4:0] {
      S_IDLE, S_GCD, S_GWAIT, S_RN, S_RNW, S_RD, S_RDW, S_CHK, S_REJ,
      S_EMIT, S_PRE, S_PREW, S_WDIV, S_WWAIT, S_ODIV, S_OWAIT, S_INT
   } st_e;

   st_e               state;
   ptab_mode_e        mode_q;
   logic [RAT_W-1:0]  n0, d0, gx, gy, rn, rd, idx;
   logic [ACC_W-1:0]  r;
   logic [WT_W-1:0]   wt_q;
   logic              hdr_q, vld_q, last_q;
   logic [WORD_W-1:0] word_q;

   logic              is_last;
   logic [WT_W-1:0]   wt_new;
   logic [ACC_W-1:0]  frac_sum;
   logic              frac_step;
   logic [ACC_W-1:0]  down_sum;
   logic              unused_bits;

   always_comb begin
      is_last   = (idx == rn - 1'b1);
      wt_new    = UNITY - div_quo[WT_W-1:0];
      frac_sum  = r + ACC_W'(rd);
      frac_step = (frac_sum >= ACC_W'(rn));
      down_sum  = r + {1'b0, rd, 1'b0};
   end

   assign unused_bits = ^{div_quo, div_rem};

   // divider operand selection
   always_comb begin
      div_start = 1'b0;
      div_dvd   = '0;
      div_dvs   = '0;
      case (state)
         S_GCD: begin
            div_start = (gy != '0);
            div_dvd   = DVD_W'(gx);
            div_dvs   = DVS_W'(gy);
         end
         S_RN: begin
            div_start = 1'b1;
            div_dvd   = DVD_W'(n0);
            div_dvs   = DVS_W'(gx);
         end
         S_RD: begin
            div_start = 1'b1;
            div_dvd   = DVD_W'(d0);
            div_dvs   = DVS_W'(gx);
         end
         S_PRE: begin
            div_start = 1'b1;
            div_dvd   = DVD_W'(rd - rn);
            div_dvs   = {rn, 1'b0};
         end
         S_WDIV: begin
            div_start = 1'b1;
            div_dvd   = {r[RAT_W:0], {WT_SH{1'b0}}};
            div_dvs   = (mode_q == MODE_DOWN) ? {rn, 1'b0} : {1'b0, rn};
         end
         S_ODIV: begin
            div_start = 1'b1;
            div_dvd   = DVD_W'(down_sum);
            div_dvs   = {rn, 1'b0};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         mode_q <= MODE_NONE;
         n0 <= '0; d0 <= '0; gx <= '0; gy <= '0;
         rn <= '0; rd <= '0; idx <= '0;
         r      <= '0;
         wt_q   <= '0;
         hdr_q  <= 1'b0;
         vld_q  <= 1'b0;
         last_q <= 1'b0;
         word_q <= '0;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               n0     <= req_num;
               d0     <= req_denom;
               gx     <= req_num;
               gy     <= req_denom;
               mode_q <= MODE_NONE;
               state  <= (req_num == '0 || req_denom == '0) ? S_REJ : S_GCD;
            end
            S_GCD:  state <= (gy == '0) ? S_RN : S_GWAIT;
            S_GWAIT: if (div_done) begin
               gx    <= gy;
               gy    <= div_rem[RAT_W-1:0];
               state <= S_GCD;
            end
            S_RN:   state <= S_RNW;
            S_RNW: if (div_done) begin
               rn    <= div_quo[RAT_W-1:0];
               state <= S_RD;
            end
            S_RD:   state <= S_RDW;
            S_RDW: if (div_done) begin
               rd    <= div_quo[RAT_W-1:0];
               state <= S_CHK;
            end
            S_CHK: begin
               if (rn > TAB_LIM) begin
                  state <= S_REJ;
               end else begin
                  if (rd > rn)               mode_q <= MODE_DOWN;
                  else if (rd == RAT_W'(1))  mode_q <= MODE_INT;
                  else                       mode_q <= MODE_FRAC;
                  r      <= '0;
                  idx    <= '0;
                  hdr_q  <= 1'b1;
                  vld_q  <= 1'b1;
                  last_q <= 1'b0;
                  word_q <= '1;
                  state  <= S_EMIT;
               end
            end
            S_REJ:  state <= S_IDLE;
            S_EMIT: if (out_ready) begin
               vld_q <= 1'b0;
               hdr_q <= 1'b0;
               if (last_q)                             state <= S_IDLE;
               else if (hdr_q && mode_q == MODE_DOWN)  state <= S_PRE;
               else if (mode_q == MODE_INT)            state <= S_INT;
               else                                    state <= S_WDIV;
            end
            S_PRE:  state <= S_PREW;
            S_PREW: if (div_done) begin
               r     <= ACC_W'(div_rem);
               state <= S_WDIV;
            end
            S_WDIV: state <= S_WWAIT;
            S_WWAIT: if (div_done) begin
               wt_q <= wt_new;
               if (mode_q == MODE_FRAC) begin
                  r      <= frac_step ? frac_sum - ACC_W'(rn) : frac_sum;
                  word_q <= {1'b0, RAT_W'(frac_step), wt_new};
                  last_q <= is_last;
                  idx    <= idx + 1'b1;
                  vld_q  <= 1'b1;
                  state  <= S_EMIT;
               end else begin
                  state <= S_ODIV;
               end
            end
            S_ODIV: state <= S_OWAIT;
            S_OWAIT: if (div_done) begin
               r      <= ACC_W'(div_rem);
               word_q <= {1'b0, div_quo[RAT_W-1:0], wt_q};
               last_q <= is_last;
               idx    <= idx + 1'b1;
               vld_q  <= 1'b1;
               state  <= S_EMIT;
            end
            S_INT: begin
               word_q <= {1'b1, RAT_W'(is_last), UNITY};
               last_q <= is_last;
               idx    <= idx + 1'b1;
               vld_q  <= 1'b1;
               state  <= S_EMIT;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state != S_IDLE);
   assign err       = (state == S_REJ);
   assign mode      = mode_q;
   assign out_valid = vld_q;
   assign out_word  = word_q;
   assign out_last  = last_q;

   AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last))); // R9
   AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy); // R10
   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err); // R2
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!out_valid && mode == MODE_NONE)); // R2
   AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mode != MODE_NONE)); // R4
   AST_WEIGHT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_word != '1) |->
         (out_word[WT_W-1:0] <= UNITY && out_word[WT_W-1:0] != '0)); // R7
   AST_FRAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode == MODE_FRAC && out_word != '1) |->
         (out_word[WT_W+RAT_W-1:WT_W] <= RAT_W'(1))); // R5

endmodule

// File: rtl/ptab_seq.sv
// Top: sequencer plus its shared serial divider.
module ptab_seq #(
   parameter int RAT_W   = 8,
   parameter int TABLE_N = 31,
   parameter int WT_SH   = 9
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [RAT_W-1:0]       req_num,
   input  logic [RAT_W-1:0]       req_denom,
   output logic                   busy,
   output logic                   err,
   output logic [1:0]             mode,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [RAT_W+WT_SH+1:0] out_word,
   output logic                   out_last
);

   localparam int DVD_W = RAT_W + WT_SH + 1;
   localparam int DVS_W = RAT_W + 1;

   logic             div_start, div_done;
   logic [DVD_W-1:0] div_dvd, div_quo;
   logic [DVS_W-1:0] div_dvs, div_rem;

   ptab_ctrl #(.RAT_W(RAT_W), .TABLE_N(TABLE_N), .WT_SH(WT_SH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_num   (req_num),
      .req_denom (req_denom),
      .busy      (busy),
      .err       (err),
      .mode      (mode),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_word  (out_word),
      .out_last  (out_last),
      .div_start (div_start),
      .div_dvd   (div_dvd),
      .div_dvs   (div_dvs),
      .div_done  (div_done),
      .div_quo   (div_quo),
      .div_rem   (div_rem)
   );

   ptab_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (div_dvd),
      .divisor  (div_dvs),
      .done     (div_done),
      .quo      (div_quo),
      .rem      (div_rem)
   );

endmodule

// File: tb/sim_ptab_seq.sv
module sim_ptab_seq;

   localparam int CLK_PERIOD = 10;
   localparam int RW   = 8;
   localparam int TN   = 31;
   localparam int WS   = 9;
   localparam int WW   = RW + WS + 2;
   localparam int WDOG = 190000;
   localparam int NSTIM = 17;
   localparam int STIM [0:NSTIM-1][0:1] = '{
      '{1, 1}, '{2, 1}, '{31, 1}, '{32, 1}, '{62, 2}, '{64, 2},
      '{5, 3}, '{3, 5}, '{1, 255}, '{31, 255}, '{17, 200}, '{255, 254},
      '{31, 30}, '{30, 31}, '{0, 5}, '{5, 0}, '{248, 8}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [RW-1:0] req_num = '0;
   logic [RW-1:0] req_denom = '0;
   logic          busy, err, out_valid, out_last;
   logic          out_ready = 1'b0;
   logic [1:0]    mode;
   logic [WW-1:0] out_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptab_seq #(.RAT_W(RW), .TABLE_N(TN), .WT_SH(WS)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
      .req_denom(req_denom), .busy(busy), .err(err), .mode(mode),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .out_last(out_last)
   );

   int            n_chk = 0;
   int            n_bad = 0;
   int            pat = 0;
   logic [WW-1:0] exp_word [0:63];
   int            exp_len;
   bit            exp_rej;
   logic [1:0]    exp_mode;

   task automatic check(input bit ok, input string req,
                        input logic [WW-1:0] act, input logic [WW-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic string entry_tag(input logic [1:0] m);
      if (m == 2'd1) return "R7 shrink entry";
      if (m == 2'd2) return "R6 whole-factor entry";
      return "R5 fractional entry";
   endfunction

   // independent integer model of the requirements
   task automatic ref_model(input int n, input int d);
      int a, b, t, rn, rd, acc, w, o, nr;
      exp_len  = 0;
      exp_rej  = 1'b0;
      exp_mode = 2'd0;
      if (n == 0 || d == 0) begin exp_rej = 1'b1; return; end
      a = n; b = d;
      while (b != 0) begin t = a % b; a = b; b = t; end
      rn = n / a; rd = d / a;
      if (rn > TN) begin exp_rej = 1'b1; return; end
      exp_word[0] = '1;
      exp_len = 1;
      if (rd > rn) exp_mode = 2'd1;
      else if (rd == 1) exp_mode = 2'd2;
      else exp_mode = 2'd3;
      acc = (exp_mode == 2'd1) ? rd : 0;
      for (int i = 0; i < rn; i++) begin
         nr = 0;
         if (exp_mode == 2'd1) begin
            acc = rn + (acc - rn) % (2 * rn);
            w   = 512 - 512 * (acc - rn) / (2 * rn);
            acc = acc + 2 * rd;
            o   = (acc - rn) / (2 * rn);
         end else if (exp_mode == 2'd2) begin
            w  = 512;
            o  = (i == rn - 1) ? 1 : 0;
            nr = 1;
         end else begin
            w   = 512 - 512 * acc / rn;
            acc = acc + rd;
            o   = (acc >= rn) ? 1 : 0;
            if (o == 1) acc = acc - rn;
         end
         exp_word[exp_len] = {nr[0], o[RW-1:0], w[WS:0]};
         exp_len++;
      end
   endtask

   task automatic run_ratio(input int n, input int d, input bit poke);
      int k, guard;
      bit fin, stalled;
      logic [WW-1:0] held;
      ref_model(n, d);
      while (busy) @(negedge clk);
      req_valid = 1'b1;
      req_num   = RW'(n);
      req_denom = RW'(d);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R10 busy after accept", WW'(busy), WW'(1));
      if (poke) begin
         req_valid = 1'b1;
         req_num   = 8'd3;
         req_denom = 8'd7;
      end
      k = 0; guard = 0; fin = 1'b0; stalled = 1'b0; held = '0;
      while (!fin && guard < 20000) begin
         if (poke && guard == 3) req_valid = 1'b0;
         if (err) begin
            check(exp_rej, "R2 rejection flag", WW'(1), WW'(exp_rej));
            check(mode == 2'd0, "R2 mode on rejection", WW'(mode), WW'(0));
            fin = 1'b1;
         end else if (out_valid) begin
            if (exp_rej) begin
               check(1'b0, "R2 word on rejected ratio", out_word, '0);
               fin = 1'b1;
            end else begin
               if (stalled)
                  check(out_word == held, "R9 word held under stall", out_word, held);
               pat++;
               out_ready = (pat % 3) != 0;
               if (out_ready) begin
                  stalled = 1'b0;
                  if (k == 0) begin
                     check(out_word == exp_word[0], "R3 header word", out_word, exp_word[0]);
                     check(mode == exp_mode, "R4 mode choice", WW'(mode), WW'(exp_mode));
                  end else if (k < exp_len) begin
                     check(out_word == exp_word[k], entry_tag(exp_mode), out_word, exp_word[k]);
                  end else begin
                     check(1'b0, "R8 extra word", out_word, '0);
                  end
                  check(out_last == (k == exp_len - 1), "R8 last flag",
                        WW'(out_last), WW'(k == exp_len - 1));
                  if (out_last || k >= exp_len - 1) fin = 1'b1;
                  k++;
               end else begin
                  stalled = 1'b1;
                  held = out_word;
               end
            end
         end
         @(negedge clk);
         guard++;
      end
      out_ready = 1'b0;
      if (!fin) check(1'b0, "R10 sequence finished", WW'(guard), WW'(0));
      check(busy == 1'b0, "R10 busy falls at end", WW'(busy), WW'(0));
      check(err == 1'b0, "R2 flag lasts one cycle", WW'(err), WW'(0));
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(busy == 1'b0 && out_valid == 1'b0 && err == 1'b0 && mode == 2'd0,
            "R1 state in reset", WW'({busy, out_valid, err, mode}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && out_valid == 1'b0 && err == 1'b0 && mode == 2'd0,
            "R1 state after reset", WW'({busy, out_valid, err, mode}), '0);

      for (int s = 0; s < NSTIM; s++) run_ratio(STIM[s][0], STIM[s][1], 1'b0);

      for (int a = 1; a <= 12; a++)
         for (int b = 1; b <= 12; b++)
            run_ratio(a, b, 1'b0);

      // requests made while busy must not disturb a long shrink table
      run_ratio(29, 64, 1'b1);
      @(negedge clk);
      check(out_valid == 1'b0 && busy == 1'b0, "R10 request while busy ignored",
            WW'({busy, out_valid}), '0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule